// File: doc/BRIEF.md
# Edge-Sensitive Interrupt Port Controller

This peripheral looks after seven external pins, numbered 1 to 7, through a small register bank on a 16-bit bus. Each pin can be a general-purpose input or output, or a source of interrupts. For every pin, software chooses the direction, the interrupt enable and a 2-bit sense mode. The sense mode is either low level or one of three edge kinds. The block drives output values onto pins set as outputs. It passes every pin through a two-flop synchronizer and shows the synchronized state in a read-only register. Detected edges are caught in sticky flags that software clears by writing ones. The block raises one interrupt request line per pin.

A bus access is a single-cycle request (`bus_sel` high for one clock). The block answers one clock later with `bus_ack`, the read data and an error bit. The configuration registers accept only supervisor accesses. A user-mode access to them changes nothing and returns an error.

Word address map (`bus_addr`): 0 sense modes, 1 direction, 2 interrupt enable, 3 output data, 4 pin state (read-only), 5 edge flags, 6 and 7 reserved. In the 8-bit registers, bit n belongs to pin n and bit 0 always reads 0.

Top module: `edge_irq_port`

## Requirements
- R1: After reset every register reads 0, and `pin_oe`, `pin_out` and `irq_req` are all 0.
- R2: The sense register at address 0 gives pin n the field in bits 2n+1:2n, encoded as 00 low level, 01 rising, 10 falling, 11 both. Bits 1:0 read 0.
- R3: `pin_oe[n]` equals direction bit n (1 = output), and `pin_out[n]` equals output-data bit n when that pin is an output, else 0.
- R4: The pin state register (address 4) returns the pin inputs after a two-flop synchronizer. A pin change driven between edges shows in a read sampled at the third rising edge after the change, not at the first or second.
- R5: In edge modes, the flag (address 5) of a pin is set when its synchronized value makes a transition that matches its mode. A non-matching transition leaves the flag unchanged.
- R6: In level mode the flag is never set, and the request follows the synchronized pin: it is high while the pin is low and the pin is enabled.
- R7: `irq_req[n]` is high only when enable bit n (address 2) is 1. In edge modes it equals flag n. Flags latch even while the pin is disabled.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. The flags accept user-mode accesses.
- R9: If a flag is cleared in the same cycle that a new edge is detected on that pin, the flag stays set.
- R10: A user-mode access (`bus_priv` = 0) to address 0, 1 or 2 changes nothing and is answered with `bus_err` = 1 and read data 0. Supervisor accesses and accesses to addresses 3 to 7 never give an error.
- R11: Writes to reserved addresses 6 and 7 have no effect, and reads from them return 0.
- R12: Writes to the pin state register are ignored without error.
- R13: Every access is answered by `bus_ack` exactly one cycle after `bus_sel`, and `bus_ack` is high at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_priv | input | 1 | 1 = supervisor, 0 = user mode |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_ack | output | 1 | Access answered (one cycle after request) |
| bus_err | output | 1 | Transfer error for the answered access |
| bus_rdata | output | 16 | Read data for the answered access |
| pin_in | input | 7 | Pin inputs, bit n = pin n |
| pin_out | output | 7 | Pin output values |
| pin_oe | output | 7 | Pin output enables |
| irq_req | output | 7 | Interrupt request per pin |

## Verification
The hardest case to reach is R9: a flag must be cleared in exactly the cycle that the edge detector fires on the same pin. That cycle sits two synchronizer stages behind the pin change. The stimulus first sets the flag with an earlier edge. It then toggles the pin between edges, lets two rising edges pass, and issues the clearing write so that the bus samples it at the third edge, where the detection happens. A follow-up read must still show the flag. The three-read sequence of R4 pins down the same latency, which makes the R9 timing trustworthy.

// File: rtl/eip_pkg.sv
// Shared types and address map of the edge-sensitive interrupt port.
// Assumes a word-addressed register bank of at most eight locations.
package eip_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_RISE = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_ANY  = 2'b11
    } sense_e;

    localparam int unsigned ADR_SENSE = 0;
    localparam int unsigned ADR_DIR   = 1;
    localparam int unsigned ADR_IEN   = 2;
    localparam int unsigned ADR_DOUT  = 3;
    localparam int unsigned ADR_PINS  = 4;
    localparam int unsigned ADR_FLAG  = 5;
    localparam int unsigned ADR_LAST_SUPER = ADR_IEN;

endpackage

// File: rtl/eip_sync.sv
// Multi-stage synchronizer for the pin inputs.
// Assumes inputs are asynchronous; output is STAGES clocks behind.
module eip_sync #(
    parameter int NPIN   = 7,
    parameter int STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN:1]   raw_in,
    output logic [NPIN:1]   sync_out
);

    logic [NPIN:1] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first stage captures the raw pins
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= raw_in;
            end
        end else begin : g_next
            // later stages shift the value along
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/eip_pin_cell.sv
// One pin's edge detector, sticky flag and request generation.
// Assumes pin_sync is already synchronous; clear loses to a new edge.
module eip_pin_cell
    import eip_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_sync,
    input  logic [1:0] mode,
    input  logic       enable,
    input  logic       clr,
    output logic       flag,
    output logic       irq
);

    logic   prev_q;
    logic   flag_q;
    logic   hit;
    sense_e sense;

    assign sense = sense_e'(mode);

    // decide whether this cycle's transition matches the selected mode
    always_comb begin
        unique case (sense)
            SENSE_RISE: hit = pin_sync & ~prev_q;
            SENSE_FALL: hit = ~pin_sync & prev_q;
            SENSE_ANY:  hit = pin_sync ^ prev_q;
            default:    hit = 1'b0;
        endcase
    end

    // remember last synchronized value for transition detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_sync;
    end

    // sticky flag: set wins over write-one clear
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= (flag_q & ~clr) | hit;
    end

    assign flag = flag_q;
    assign irq  = enable & ((sense == SENSE_LOW) ? ~pin_sync : flag_q);

endmodule

// File: rtl/eip_regbank.sv
// Register bank: decode, privilege check, storage and registered reply.
// Assumes one-cycle requests; reply appears on the following cycle.
module eip_regbank
    import eip_pkg::*;
#(
    parameter int NPIN = 7,
    parameter int AW   = 3,
    parameter int DW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_priv,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NPIN:1]     pin_state,
    input  logic [NPIN:1]     flags,
    output logic [2*NPIN+1:2] cfg_sense,
    output logic [NPIN:1]     cfg_dir,
    output logic [NPIN:1]     cfg_ien,
    output logic [NPIN:1]     cfg_dout,
    output logic [NPIN:1]     flag_clr
);

    localparam int SENSE_HI = 2*NPIN + 1;

    logic          super_reg;
    logic          deny;
    logic          wr_ok;
    logic [DW-1:0] rd_mux;
    logic          ack_q;
    logic          err_q;
    logic [DW-1:0] rdata_q;
    logic          wdata_unused;

    assign wdata_unused = ^bus_wdata;

    assign super_reg = (bus_addr <= AW'(ADR_LAST_SUPER));
    assign deny      = super_reg & ~bus_priv;
    assign wr_ok     = bus_sel & bus_wr & ~deny;

    // sense-mode field storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cfg_sense <= '0;
        else if (wr_ok && bus_addr == AW'(ADR_SENSE))   cfg_sense <= bus_wdata[SENSE_HI:2];
    end

    // direction storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cfg_dir <= '0;
        else if (wr_ok && bus_addr == AW'(ADR_DIR))     cfg_dir <= bus_wdata[NPIN:1];
    end

    // interrupt enable storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cfg_ien <= '0;
        else if (wr_ok && bus_addr == AW'(ADR_IEN))     cfg_ien <= bus_wdata[NPIN:1];
    end

    // output data storage
    always_ff @(posedge clk) begin
        if (!rst_n)                                     cfg_dout <= '0;
        else if (wr_ok && bus_addr == AW'(ADR_DOUT))    cfg_dout <= bus_wdata[NPIN:1];
    end

    // write-one-to-clear strobes toward the pin cells
    assign flag_clr = (wr_ok && bus_addr == AW'(ADR_FLAG)) ? bus_wdata[NPIN:1] : '0;

    // read multiplexer; reserved locations return zero
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            AW'(ADR_SENSE): rd_mux[SENSE_HI:2] = cfg_sense;
            AW'(ADR_DIR):   rd_mux[NPIN:1]     = cfg_dir;
            AW'(ADR_IEN):   rd_mux[NPIN:1]     = cfg_ien;
            AW'(ADR_DOUT):  rd_mux[NPIN:1]     = cfg_dout;
            AW'(ADR_PINS):  rd_mux[NPIN:1]     = pin_state;
            AW'(ADR_FLAG):  rd_mux[NPIN:1]     = flags;
            default:        rd_mux             = '0;
        endcase
    end

    // registered reply: acknowledge, error and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q   <= 1'b0;
            err_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            ack_q   <= bus_sel;
            err_q   <= bus_sel & deny;
            rdata_q <= (bus_sel && !bus_wr && !deny) ? rd_mux : '0;
        end
    end

    assign bus_ack   = ack_q;
    assign bus_err   = err_q;
    assign bus_rdata = rdata_q;

endmodule

// File: rtl/edge_irq_port.sv
// Top of the edge-sensitive interrupt port: seven pins, each GPIO or
// interrupt source. Assumes NPIN <= 7 so the sense fields fit in DW.
module edge_irq_port #(
    parameter int NPIN        = 7,
    parameter int AW          = 3,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_sel,
    input  logic            bus_wr,
    input  logic            bus_priv,
    input  logic [AW-1:0]   bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic            bus_ack,
    output logic            bus_err,
    output logic [DW-1:0]   bus_rdata,
    input  logic [NPIN:1]   pin_in,
    output logic [NPIN:1]   pin_out,
    output logic [NPIN:1]   pin_oe,
    output logic [NPIN:1]   irq_req
);

    logic [2*NPIN+1:2] cfg_sense;
    logic [NPIN:1]     cfg_dir;
    logic [NPIN:1]     cfg_ien;
    logic [NPIN:1]     cfg_dout;
    logic [NPIN:1]     pin_sync;
    logic [NPIN:1]     flag_vec;
    logic [NPIN:1]     flag_clr;

    eip_sync #(.NPIN(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (pin_sync)
    );

    eip_regbank #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_priv  (bus_priv),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_ack   (bus_ack),
        .bus_err   (bus_err),
        .bus_rdata (bus_rdata),
        .pin_state (pin_sync),
        .flags     (flag_vec),
        .cfg_sense (cfg_sense),
        .cfg_dir   (cfg_dir),
        .cfg_ien   (cfg_ien),
        .cfg_dout  (cfg_dout),
        .flag_clr  (flag_clr)
    );

    for (genvar p = 1; p <= NPIN; p++) begin : g_pin
        eip_pin_cell u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_sync (pin_sync[p]),
            .mode     (cfg_sense[2*p+1:2*p]),
            .enable   (cfg_ien[p]),
            .clr      (flag_clr[p]),
            .flag     (flag_vec[p]),
            .irq      (irq_req[p])
        );
    end

    assign pin_oe  = cfg_dir;
    assign pin_out = cfg_dout & cfg_dir;

endmodule

// File: rtl/eip_checker.sv
// Protocol and state properties of edge_irq_port, attached by bind.
// Assumes the same parameters as the bound instance.
module eip_checker #(
    parameter int NPIN = 7,
    parameter int AW   = 3,
    parameter int DW   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic              bus_priv,
    input logic [AW-1:0]     bus_addr,
    input logic              bus_ack,
    input logic              bus_err,
    input logic [DW-1:0]     bus_rdata,
    input logic [2*NPIN+1:2] cfg_sense,
    input logic [NPIN:1]     cfg_ien,
    input logic [NPIN:1]     flag_vec,
    input logic [NPIN:1]     irq_req
);

    logic [NPIN:1] lvl_mask;
    logic          user_super;
    logic          flag_write;

    // which pins are in low-level mode
    always_comb begin
        for (int p = 1; p <= NPIN; p++) lvl_mask[p] = (cfg_sense[2*p+1 -: 2] == 2'b00);
    end

    assign user_super = bus_sel && !bus_priv && (bus_addr <= AW'(2));
    assign flag_write = bus_sel && bus_wr && (bus_addr == AW'(5));

    p_ack_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ack);

    p_ack_cause_r13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> $past(bus_sel));

    p_deny_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        user_super |=> (bus_err && bus_rdata == '0));

    p_allow_noerr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !user_super) |=> !bus_err);

    p_deny_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (user_super && bus_wr && bus_addr == AW'(0)) |=> $stable(cfg_sense));

    p_resv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr >= AW'(6)) |=> bus_rdata == '0);

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_write |=> ((flag_vec & $past(flag_vec)) == $past(flag_vec)));

    p_level_noflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_vec & ~$past(flag_vec) & $past(lvl_mask)) == '0);

    p_irq_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~cfg_ien) == '0);

endmodule

bind edge_irq_port eip_checker #(.NPIN(NPIN), .AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_priv  (bus_priv),
    .bus_addr  (bus_addr),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .bus_rdata (bus_rdata),
    .cfg_sense (cfg_sense),
    .cfg_ien   (cfg_ien),
    .flag_vec  (flag_vec),
    .irq_req   (irq_req)
);

// File: tb/edge_irq_port_test.sv
// Scoreboard bench for edge_irq_port: bus tasks queue expected replies,
// a monitor pops them on each acknowledge; pin outputs checked directly.
module edge_irq_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_priv = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [15:0] bus_rdata;
    logic [7:0]  pins = 8'hFE;
    logic [7:1]  pin_out, pin_oe, irq_req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    typedef struct {
        logic [15:0] rdata;
        logic        err;
        string       tag;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    edge_irq_port uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_priv(bus_priv), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .pin_in(pins[7:1]), .pin_out(pin_out), .pin_oe(pin_oe), .irq_req(irq_req)
    );

    // monitor: compare each reply with the oldest queued expectation
    always @(negedge clk) begin
        if (rst_n && bus_ack) begin
            total++;
            if (sb.size() == 0) begin
                bad++;
                $display("FAIL R13 unexpected ack");
            end else begin
                exp_t e;
                e = sb.pop_front();
                if (bus_rdata !== e.rdata || bus_err !== e.err) begin
                    bad++;
                    $display("FAIL %s rdata=%h err=%b expected rdata=%h err=%b",
                             e.tag, bus_rdata, bus_err, e.rdata, e.err);
                end
            end
        end
    end

    // one bus access; starts and ends just after a falling edge
    task automatic bus_op(input logic wr, input logic priv, input logic [2:0] a,
                          input logic [15:0] wd, input logic [15:0] exp_rd,
                          input logic exp_err, input string tag);
        exp_t e;
        e.rdata = exp_rd; e.err = exp_err; e.tag = tag;
        sb.push_back(e);
        bus_sel = 1'b1; bus_wr = wr; bus_priv = priv; bus_addr = a; bus_wdata = wd;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic sw(input logic [2:0] a, input logic [15:0] wd, input string tag);
        bus_op(1'b1, 1'b1, a, wd, 16'h0, 1'b0, tag);
    endtask

    task automatic sr(input logic [2:0] a, input logic [15:0] exp_rd, input string tag);
        bus_op(1'b0, 1'b1, a, 16'h0, exp_rd, 1'b0, tag);
    endtask

    task automatic chk8(input logic [7:1] act, input logic [7:0] exp, input string tag);
        total++;
        if (act !== exp[7:1]) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, {act, 1'b0}, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(3);

        // R1 reset state
        chk8(irq_req, 8'h00, "R1 irq");
        chk8(pin_oe, 8'h00, "R1 oe");
        chk8(pin_out, 8'h00, "R1 out");
        for (int a = 0; a < 6; a++) begin
            if (a != 4) sr(3'(a), 16'h0, "R1 reg reset");
        end

        // R4 synchronizer latency on pin state read
        pins = 8'hB4;
        sr(3'd4, 16'h00FE, "R4 first edge old");
        sr(3'd4, 16'h00FE, "R4 second edge old");
        sr(3'd4, 16'h00B4, "R4 third edge new");
        pins = 8'hFE;
        wait_cyc(3);
        sr(3'd5, 16'h0, "R6 level mode no flags");

        // R2 sense field placement
        sw(3'd0, 16'hFFFF, "R2 write");
        sr(3'd0, 16'hFFFC, "R2 low bits zero");
        sw(3'd0, 16'hE4B4, "R2 write modes");
        sr(3'd0, 16'hE4B4, "R2 readback");

        // R3 direction and output data
        sw(3'd1, 16'h00F0, "R3 dir");
        sw(3'd3, 16'h00AA, "R3 data");
        chk8(pin_oe, 8'hF0, "R3 oe");
        chk8(pin_out, 8'hA0, "R3 out masked");
        sr(3'd1, 16'h00F0, "R3 dir read");
        sr(3'd3, 16'h00AA, "R3 data read");

        // R7 flag latches while disabled, request follows enable
        pins[1] = 1'b0; wait_cyc(3);
        pins[1] = 1'b1; wait_cyc(3);
        sr(3'd5, 16'h0002, "R7 flag while disabled");
        chk8(irq_req, 8'h00, "R7 no irq disabled");
        sw(3'd2, 16'h0002, "R7 enable");
        chk8(irq_req, 8'h02, "R7 irq follows flag");

        // R8 write-one clear
        sw(3'd5, 16'h0000, "R8 write zero");
        sr(3'd5, 16'h0002, "R8 zero keeps");
        bus_op(1'b1, 1'b0, 3'd5, 16'h0002, 16'h0, 1'b0, "R8 user clear");
        chk8(irq_req, 8'h00, "R8 irq dropped");
        sr(3'd5, 16'h0000, "R8 cleared");

        // R5 falling transition set: falling 3,6 and both 2,7
        pins = 8'h10; wait_cyc(3);
        sr(3'd5, 16'h00CC, "R5 falling");
        sw(3'd5, 16'h00FE, "R5 clear");
        pins = 8'hFE; wait_cyc(3);
        sr(3'd5, 16'h00A6, "R5 rising");
        sw(3'd5, 16'h00FE, "R5 clear2");
        sr(3'd5, 16'h0000, "R5 clear done");

        // R6 level request timing on pin 4
        sw(3'd2, 16'h0010, "R6 enable pin4");
        pins[4] = 1'b0;
        wait_cyc(1);
        chk8(irq_req, 8'h00, "R6 not yet");
        wait_cyc(1);
        chk8(irq_req, 8'h10, "R6 level irq");
        sr(3'd5, 16'h0000, "R6 no flag");
        pins[4] = 1'b1; wait_cyc(3);
        chk8(irq_req, 8'h00, "R6 released");

        // R9 clear in the detection cycle (pin 2, both edges)
        pins[2] = 1'b0; wait_cyc(3);
        sr(3'd5, 16'h0004, "R9 armed");
        pins[2] = 1'b1;
        wait_cyc(2);
        sw(3'd5, 16'h0004, "R9 racing clear");
        sr(3'd5, 16'h0004, "R9 flag kept");
        sw(3'd5, 16'h0004, "R9 plain clear");
        sr(3'd5, 16'h0000, "R9 cleared");

        // R10 user access to supervisor registers
        bus_op(1'b1, 1'b0, 3'd0, 16'h0000, 16'h0, 1'b1, "R10 user write sense");
        sr(3'd0, 16'hE4B4, "R10 sense unchanged");
        bus_op(1'b0, 1'b0, 3'd1, 16'h0, 16'h0, 1'b1, "R10 user read dir");
        bus_op(1'b1, 1'b0, 3'd2, 16'h00FE, 16'h0, 1'b1, "R10 user write ien");
        sr(3'd2, 16'h0010, "R10 ien unchanged");
        bus_op(1'b1, 1'b0, 3'd3, 16'h000E, 16'h0, 1'b0, "R10 user data ok");
        bus_op(1'b0, 1'b0, 3'd3, 16'h0, 16'h000E, 1'b0, "R10 user data read");

        // R11 reserved locations
        sw(3'd6, 16'hFFFF, "R11 write resv");
        sw(3'd7, 16'hFFFF, "R11 write resv7");
        sr(3'd6, 16'h0000, "R11 read resv");
        sr(3'd7, 16'h0000, "R11 read resv7");
        sr(3'd3, 16'h000E, "R11 data intact");
        sr(3'd1, 16'h00F0, "R11 dir intact");

        // R12 pin state is read-only
        sw(3'd4, 16'h0000, "R12 write pins");
        sr(3'd4, 16'h00FE, "R12 pins unchanged");

        wait_cyc(2);
        total++;
        if (sb.size() != 0) begin
            bad++;
            $display("FAIL R13 missing replies actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule